// File: doc/BRIEF.md
# PWM Pulse Generator

This block produces a periodic pulse train from two run-time settings: a period length and a pulse length, both counted in clock cycles. A down-counter steps from the period length minus one to zero, and the pulse is driven high during the final cycles of each count, when the counter has fallen below the pulse length. The live counter value is driven out beside the pulse, so neighbouring logic can schedule its own events at a known offset from the pulse.

New settings are presented on the period and width inputs together with a one-cycle load strobe. They are held in a pending stage and moved into use only when the counter wraps through zero, so a period in progress is never cut short or given a partial pulse. Because the pulse sits at the low end of the down-count, a width setting larger than the period keeps the output low rather than stuck high. All pins are plain control and status signals; no data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `pwm_pulse_gen`

## Requirements
- R1: While `count_o` is not zero, it decreases by exactly one on every clock cycle.
- R2: When `count_o` is zero, on the next cycle it takes the active period minus one; an active period of 0 or 1 keeps it at zero, giving a one-cycle period.
- R3: `pulse_o` is high exactly in the cycles where `count_o` is below the active width (width not zero and not above the period), so the pulse fills the last width cycles of each period and is aligned with `count_o`.
- R4: When the active width is greater than the active period, `pulse_o` stays low in every cycle.
- R5: A load captures `cfg_period` and `cfg_width` into a pending stage; they become active only at the first reload after the capturing edge, the period already running keeps its old settings, and the last of several loads before a reload wins.
- R6: While `rst` is high, `count_o` and `pulse_o` are zero, loads are ignored and the pending and active settings are cleared to zero; after release the output stays low with `count_o` at zero until settings are loaded.
- R7: An active width of zero keeps `pulse_o` low; an active width equal to the period keeps `pulse_o` high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_period | input | CNT_W | Period length in cycles, captured on load |
| cfg_width | input | CNT_W | Pulse length in cycles, captured on load |
| cfg_load | input | 1 | One-cycle strobe capturing both settings |
| pulse_o | output | 1 | Registered pulse output |
| count_o | output | CNT_W | Current down-counter value |

## Verification
Every cycle, the assertions check the single-step decrement, the reload value after zero, that the active settings only change at a reload, the pulse against the counter and active settings, the forced-low cases for oversized and zero widths, and the cleared state after reset. Which period a load lands in, last-load-wins, loads ignored during reset and the exact cycle of the first pulse after a change can only be seen in the bench scenarios. Those scenarios are checked cycle by cycle against a model that the bench builds from the requirements.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Classification of one cycle of the pulse train.
  typedef enum logic [1:0] {
    PH_OFF    = 2'd0,  // settings forbid any pulse (zero or oversized width)
    PH_GAP    = 2'd1,  // counter still above the width: output low
    PH_ACTIVE = 2'd2   // counter inside the final width cycles: output high
  } pwm_phase_e;

endpackage

// File: rtl/pwm_cfg_stage.sv
module pwm_cfg_stage #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic             reload_i,
  output logic [CNT_W-1:0] act_period_o,
  output logic [CNT_W-1:0] act_width_o,
  output logic [CNT_W-1:0] nxt_period_o,
  output logic [CNT_W-1:0] nxt_width_o
);

  logic [CNT_W-1:0] pend_period_q, pend_width_q;
  logic [CNT_W-1:0] act_period_q, act_width_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_period_q <= '0;
      pend_width_q  <= '0;
      act_period_q  <= '0;
      act_width_q   <= '0;
    end else begin
      if (reload_i) begin
        act_period_q <= pend_period_q;
        act_width_q  <= pend_width_q;
      end
      if (load_i) begin
        pend_period_q <= period_i;
        pend_width_q  <= width_i;
      end
    end
  end

  // Settings in force for the cycle being computed.
  assign nxt_period_o = reload_i ? pend_period_q : act_period_q;
  assign nxt_width_o  = reload_i ? pend_width_q  : act_width_q;
  assign act_period_o = act_period_q;
  assign act_width_o  = act_width_q;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !reload_i |=> ($stable(act_period_q) && $stable(act_width_q))); // R5

endmodule

// File: rtl/pwm_down_counter.sv
module pwm_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] nxt_period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, reload_val;
  logic             wrap;

  assign wrap       = (cnt_q == '0);
  assign reload_val = (nxt_period_i == '0) ? '0 : (nxt_period_i - ONE);
  assign cnt_d      = wrap ? reload_val : (cnt_q - ONE);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = rst ? '0 : cnt_d;
  assign wrap_o    = wrap;

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
    !wrap_o |=> (cnt_q == $past(cnt_q) - ONE)); // R1

endmodule

// File: rtl/pwm_pulse_shaper.sv
module pwm_pulse_shaper
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] nxt_period_i,
  input  logic [CNT_W-1:0] nxt_width_i,
  output logic             pulse_o
);

  pwm_phase_e phase_d;
  logic       pulse_q;

  always_comb begin
    if (nxt_width_i == '0 || nxt_width_i > nxt_period_i)
      phase_d = PH_OFF;
    else if (cnt_nxt_i < nxt_width_i)
      phase_d = PH_ACTIVE;
    else
      phase_d = PH_GAP;
  end

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= (phase_d == PH_ACTIVE);
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/pwm_pulse_gen.sv
module pwm_pulse_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_width,
  input  logic             cfg_load,
  output logic             pulse_o,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] act_period, act_width, nxt_period, nxt_width;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             wrap;

  pwm_cfg_stage #(.CNT_W(CNT_W)) u_cfg (
    .clk          (clk),
    .rst          (rst),
    .load_i       (cfg_load),
    .period_i     (cfg_period),
    .width_i      (cfg_width),
    .reload_i     (wrap),
    .act_period_o (act_period),
    .act_width_o  (act_width),
    .nxt_period_o (nxt_period),
    .nxt_width_o  (nxt_width)
  );

  pwm_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst          (rst),
    .nxt_period_i (nxt_period),
    .cnt_o        (cnt),
    .cnt_nxt_o    (cnt_nxt),
    .wrap_o       (wrap)
  );

  pwm_pulse_shaper #(.CNT_W(CNT_W)) u_shape (
    .clk          (clk),
    .rst          (rst),
    .cnt_nxt_i    (cnt_nxt),
    .nxt_period_i (nxt_period),
    .nxt_width_i  (nxt_width),
    .pulse_o      (pulse_o)
  );

  assign count_o = cnt;

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (count_o == '0 && !pulse_o)); // R6

  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    (count_o == '0) |=> (count_o == ((act_period == '0) ? '0 : act_period - ONE))); // R2

  AST_PULSE_ALIGN: assert property (@(posedge clk) disable iff (rst)
    pulse_o == (act_width != '0 && act_width <= act_period && count_o < act_width)); // R3

  AST_WIDE_LOW: assert property (@(posedge clk) disable iff (rst)
    (act_width > act_period) |-> !pulse_o); // R4

  AST_ZERO_WIDTH_LOW: assert property (@(posedge clk) disable iff (rst)
    (act_width == '0) |-> !pulse_o); // R7

endmodule

// File: tb/pwm_pulse_gen_tb.sv
`timescale 1ns/1ps
module pwm_pulse_gen_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] cfg_period = '0;
  logic [W-1:0] cfg_width = '0;
  logic         cfg_load = 1'b0;
  logic         pulse_o;
  logic [W-1:0] count_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string ctx = "";

  // reference state
  int m_pp = 0, m_pw = 0, m_ap = 0, m_aw = 0, m_cnt = 0;
  bit m_pulse = 1'b0;

  always #5 clk = ~clk;

  pwm_pulse_gen #(.CNT_W(W)) u_dut (
    .clk(clk), .rst(rst), .cfg_period(cfg_period), .cfg_width(cfg_width),
    .cfg_load(cfg_load), .pulse_o(pulse_o), .count_o(count_o)
  );

  function automatic bit exp_pulse(int c, int p, int w);
    return (w != 0) && (w <= p) && (c < w);
  endfunction

  task automatic step(input bit ld, input int p, input int w, input bit r);
    bit was_zero;
    string ct, pt;
    @(negedge clk);
    rst = r; cfg_load = ld; cfg_period = W'(p); cfg_width = W'(w);
    @(posedge clk);
    was_zero = (m_cnt == 0);
    if (r) begin
      m_pp = 0; m_pw = 0; m_ap = 0; m_aw = 0; m_cnt = 0; m_pulse = 0;
    end else begin
      if (was_zero) begin
        m_ap = m_pp; m_aw = m_pw;
        m_cnt = (m_ap == 0) ? 0 : m_ap - 1;
      end else m_cnt = m_cnt - 1;
      if (ld) begin m_pp = p; m_pw = w; end
      m_pulse = exp_pulse(m_cnt, m_ap, m_aw);
    end
    #2;
    ct = r ? "R6" : (was_zero ? "R2" : "R1");
    if (ctx != "") pt = ctx;
    else if (r) pt = "R6";
    else if (m_aw > m_ap) pt = "R4";
    else if (m_aw == 0 || m_aw == m_ap) pt = "R7";
    else pt = "R3";
    checks++;
    if (int'(count_o) != m_cnt) begin
      errors++;
      $display("FAIL %s count_o actual %0d expected %0d", ct, count_o, m_cnt);
    end
    checks++;
    if (pulse_o !== m_pulse) begin
      errors++;
      $display("FAIL %s pulse_o actual %0b expected %0b", pt, pulse_o, m_pulse);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 1'b0);
  endtask

  initial begin
    int dummy;
    dummy = $urandom(32'd20240607);
    // R6: reset state, loads ignored during reset
    step(1'b0, 0, 0, 1'b1);
    step(1'b1, 9, 3, 1'b1);
    step(1'b0, 0, 0, 1'b1);
    run(4);                       // R6: stays idle with cleared settings
    // R1 R2 R3: basic train
    step(1'b1, 6, 2, 1'b0);
    run(20);
    // R5: load mid-period, current period keeps old settings
    run(2);
    ctx = "R5";
    step(1'b1, 4, 3, 1'b0);
    run(12);
    // R5: several loads before a reload, last wins
    step(1'b1, 10, 1, 1'b0);
    step(1'b1, 3, 2, 1'b0);
    run(12);
    ctx = "";
    // R4: oversized width
    step(1'b1, 5, 7, 1'b0);
    run(14);
    // R7: width equal to period, then zero width
    step(1'b1, 5, 5, 1'b0);
    run(14);
    step(1'b1, 5, 0, 1'b0);
    run(12);
    // R2: period 0 and period 1
    step(1'b1, 0, 0, 1'b0);
    run(6);
    step(1'b1, 1, 1, 1'b0);
    run(6);
    step(1'b1, 0, 1, 1'b0);
    run(6);
    // R6: reset mid-run
    step(1'b1, 8, 3, 1'b0);
    run(5);
    step(1'b0, 0, 0, 1'b1);
    run(4);
    // constrained random mix
    for (int s = 0; s < 300; s++) begin
      int p, w, len;
      p = $urandom_range(0, 24);
      w = ($urandom_range(0, 5) == 0) ? $urandom_range(0, 30) : $urandom_range(0, p);
      len = $urandom_range(1, 30);
      step(1'b1, p, w, ($urandom_range(0, 60) == 0));
      for (int k = 0; k < len; k++) step(1'b0, 0, 0, 1'b0);
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule